// File: doc/BRIEF.md
# Three-Wire Serial Memory Command Receiver

This block is the device side of a three-wire serial memory port (select, serial clock, serial data in, serial data out). All pins are resampled into one system clock. Once select is high, the block waits for a framing bit, then collects an operation code, an address and, for the two data-carrying operations, a 16-bit word. It executes the result against a small internal word array. It can shift a stored word back out. After a programming operation it reports busy or ready on the data-out pin.

The serial pins carry bit streams, not parallel data, so there is no valid/ready handshake at the block's edge. The pins are plain control and data lines. The host controls pacing entirely through the serial clock and may stall between clock pulses for any length of time. The address width is a parameter (6 or 8 bits), as are the minimum deselect time and the length of the simulated programming cycle.

Top module: `tw_serial_front`

## Requirements
- R1: `cs`, `sk` and `di` pass through a two-flop synchronizer. `di` is taken only at a rising `sk` seen while `cs` is high. Changes of `di` while `sk` is steady have no effect.
- R2: The framing bit is the first rising `sk` after `cs` goes high at which `di` is 1. Earlier rising edges with `di` at 0 are idle pulses and do not advance the command.
- R3: After the framing bit the block takes a 2-bit code, then ADDR_W address bits, then DATA_W data bits, each field MSB first. Code 10 is read, 01 is write (with data), 11 is erase one word. Code 00 uses the two top address bits: 11 unlocks, 00 locks, 10 erases every word, 01 writes every word (with data).
- R4: With `cs` low, SK and DI have no effect and `do_oe` is 0. A falling `cs` ends any command in progress.
- R5: If `cs` was low for fewer than CS_GAP system clocks, the whole following selection is ignored: no framing bit is taken and `do_oe` stays 0.
- R6: On a read, `do_o` is 0 with `do_oe` high after the last address bit. Each later rising `sk` presents the next of the 16 data bits, MSB first. The rising edge after the last bit releases `do_oe`.
- R7: A write, erase or fill takes effect when `cs` falls, and only if its full frame was received. A frame cut short by `cs` is discarded.
- R8: Erase sets the addressed word to FFFF. Erase-all sets every word to FFFF. Write-all sets every word to the given data.
- R9: Programming operations are ignored after reset or after a lock, and accepted after an unlock.
- R10: After an accepted programming operation, while `cs` is high and no new frame has begun, `do_oe` is 1. `do_o` is 0 for BUSY_CYC system clocks from the falling `cs`, then 1.
- R11: While ready is shown, a rising `sk` with `di` at 1 is a framing bit that begins a new command, and `di` at 0 keeps the ready status. While busy is shown, rising `sk` edges are ignored.
- R12: Synchronous active-high reset clears every word to 0, locks programming and releases `do_oe`.
- R13: With ADDR_W = 6, the framing bit, code and address take 9 clocks, so 7 idle pulses pad a read to a 16-clock host frame. With ADDR_W = 8 the figures are 11 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data into the block |
| do_o | output | 1 | Serial data / status out |
| do_oe | output | 1 | Output enable for `do_o` (tri-state control) |

## Verification
The hardest state to reach is the ready period after a programming operation, where a high `di` on a rising `sk` counts as a framing bit. To get there, the stimulus first unlocks, then completes a full write frame, lowers `cs` past the deselect minimum and raises it again. It then either clocks while busy is still shown, or waits past the busy count before clocking with `di` high or low. In the high case, the remaining read frame is appended, and the bench confirms from the returned word that the status bit was taken as the framing bit.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [2:0] {
    OP_NONE, OP_READ, OP_WRITE, OP_ERASE, OP_ERAL, OP_WRAL, OP_UNLOCK, OP_LOCK
  } tw_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_CODE, S_ADDR, S_DATA, S_READ, S_HOLD, S_REJECT
  } tw_state_e;

  function automatic tw_op_e tw_decode(input logic [1:0] code, input logic [1:0] sub);
    tw_op_e op;
    case (code)
      2'b10: op = OP_READ;
      2'b01: op = OP_WRITE;
      2'b11: op = OP_ERASE;
      default: begin
        case (sub)
          2'b11:   op = OP_UNLOCK;
          2'b00:   op = OP_LOCK;
          2'b10:   op = OP_ERAL;
          default: op = OP_WRAL;
        endcase
      end
    endcase
    return op;
  endfunction

  function automatic logic tw_has_data(input tw_op_e op);
    return (op == OP_WRITE) || (op == OP_WRAL);
  endfunction

  function automatic logic tw_is_prog(input tw_op_e op);
    return (op == OP_WRITE) || (op == OP_ERASE) || (op == OP_ERAL) || (op == OP_WRAL);
  endfunction

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/tw_store.sv
module tw_store
  import tw_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int BUSY_CYC = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_vld,
  input  tw_op_e            cmd_op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              prog_go,
  output logic              busy,
  output logic              wen
);
  localparam int WORDS  = 2 ** ADDR_W;
  localparam int BUSY_W = $clog2(BUSY_CYC + 1);

  logic [DATA_W-1:0] words [WORDS];
  logic [BUSY_W-1:0] busy_cnt;

  assign prog_go = cmd_vld && tw_is_prog(cmd_op) && wen;

  always_ff @(posedge clk) begin
    if (rst) begin
      wen <= 1'b0;
    end else if (cmd_vld && cmd_op == OP_UNLOCK) begin
      wen <= 1'b1;
    end else if (cmd_vld && cmd_op == OP_LOCK) begin
      wen <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt <= '0;
    end else if (prog_go) begin
      busy_cnt <= BUSY_W'(BUSY_CYC);
    end else if (busy_cnt != '0) begin
      busy_cnt <= busy_cnt - 1'b1;
    end
  end

  assign busy = (busy_cnt != '0);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic              hit;
    assign hit = (addr == ADDR_W'(w));
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= '0;
      end else if (prog_go) begin
        case (cmd_op)
          OP_WRITE: if (hit) word_q <= cmd_data;
          OP_ERASE: if (hit) word_q <= '1;
          OP_ERAL:  word_q <= '1;
          OP_WRAL:  word_q <= cmd_data;
          default:  word_q <= word_q;
        endcase
      end
    end
    assign words[w] = word_q;
  end

  assign rd_data = words[addr];
endmodule

// File: rtl/tw_rx.sv
module tw_rx
  import tw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int CS_GAP = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              sk_rise,
  input  logic              di_s,
  input  logic              busy,
  input  logic              prog_go,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr,
  output logic              cmd_vld,
  output tw_op_e            cmd_op,
  output logic [DATA_W-1:0] cmd_data,
  output logic              do_o,
  output logic              do_oe,
  output logic              waiting,
  output logic              rd_active,
  output logic              stat_shown
);
  localparam int MAXB  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CNT_W = $clog2(MAXB + 1);
  localparam int GAP_W = $clog2(CS_GAP + 1);

  tw_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        code;
  logic [DATA_W-1:0] data;
  logic [DATA_W-1:0] sh;
  logic [GAP_W-1:0]  gap_cnt;
  logic              cs_q, done, stat_pend, rd_oe, rd_bit;
  logic              cs_rise, cs_fall, armed;
  logic [ADDR_W-1:0] addr_nx;
  tw_op_e            op_q, op_nx;

  assign cs_rise = cs_s & ~cs_q;
  assign cs_fall = ~cs_s & cs_q;
  assign armed   = (gap_cnt == GAP_W'(CS_GAP));
  assign addr_nx = {addr[ADDR_W-2:0], di_s};
  assign op_nx   = tw_decode(code, addr_nx[ADDR_W-1 -: 2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q    <= 1'b0;
      gap_cnt <= GAP_W'(CS_GAP);
    end else begin
      cs_q <= cs_s;
      if (cs_s) gap_cnt <= '0;
      else if (!armed) gap_cnt <= gap_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      code      <= '0;
      addr      <= '0;
      data      <= '0;
      sh        <= '0;
      op_q      <= OP_NONE;
      done      <= 1'b0;
      stat_pend <= 1'b0;
      rd_oe     <= 1'b0;
      rd_bit    <= 1'b0;
      cmd_vld   <= 1'b0;
    end else begin
      cmd_vld <= 1'b0;
      if (cs_fall) begin
        state <= S_IDLE;
        rd_oe <= 1'b0;
        done  <= 1'b0;
        if (done && op_q != OP_READ) cmd_vld <= 1'b1;
      end else if (cs_rise) begin
        state <= armed ? S_WAIT : S_REJECT;
      end else if (sk_rise) begin
        case (state)
          S_WAIT: begin
            if (di_s && !(stat_pend && busy)) begin
              state     <= S_CODE;
              cnt       <= '0;
              stat_pend <= 1'b0;
            end
          end
          S_CODE: begin
            code <= {code[0], di_s};
            if (cnt == CNT_W'(1)) begin
              state <= S_ADDR;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_ADDR: begin
            addr <= addr_nx;
            if (cnt == CNT_W'(ADDR_W - 1)) begin
              op_q <= op_nx;
              cnt  <= '0;
              if (op_nx == OP_READ) begin
                state  <= S_READ;
                rd_oe  <= 1'b1;
                rd_bit <= 1'b0;
              end else if (tw_has_data(op_nx)) begin
                state <= S_DATA;
              end else begin
                state <= S_HOLD;
                done  <= 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            data <= {data[DATA_W-2:0], di_s};
            if (cnt == CNT_W'(DATA_W - 1)) begin
              state <= S_HOLD;
              done  <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_READ: begin
            if (cnt == CNT_W'(DATA_W)) begin
              state <= S_HOLD;
              rd_oe <= 1'b0;
            end else begin
              if (cnt == '0) begin
                rd_bit <= rd_data[DATA_W-1];
                sh     <= {rd_data[DATA_W-2:0], 1'b0};
              end else begin
                rd_bit <= sh[DATA_W-1];
                sh     <= {sh[DATA_W-2:0], 1'b0};
              end
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= state;
        endcase
      end
      if (prog_go) stat_pend <= 1'b1;
    end
  end

  assign waiting    = (state == S_WAIT);
  assign stat_shown = waiting && stat_pend;
  assign rd_active  = rd_oe;
  assign do_oe      = rd_oe | stat_shown;
  assign do_o       = rd_oe ? rd_bit : (stat_shown & ~busy);
  assign cmd_op     = op_q;
  assign cmd_data   = data;
endmodule

// File: rtl/tw_serial_front.sv
module tw_serial_front
  import tw_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int CS_GAP   = 6,
  parameter int BUSY_CYC = 48
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_o,
  output logic do_oe
);
  logic [2:0]        pins_s;
  logic              cs_s, sk_s, di_s, sk_q, sk_rise;
  logic              busy, prog_go, wen, cmd_vld;
  logic              waiting, rd_active, stat_shown;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] rd_data, cmd_data;
  tw_op_e            cmd_op;

  tw_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs, sk, di}),
    .q   (pins_s)
  );

  assign cs_s = pins_s[2];
  assign sk_s = pins_s[1];
  assign di_s = pins_s[0];

  always_ff @(posedge clk) begin
    if (rst) sk_q <= 1'b0;
    else     sk_q <= sk_s;
  end

  assign sk_rise = sk_s & ~sk_q & cs_s;

  tw_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CS_GAP(CS_GAP)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .cs_s       (cs_s),
    .sk_rise    (sk_rise),
    .di_s       (di_s),
    .busy       (busy),
    .prog_go    (prog_go),
    .rd_data    (rd_data),
    .addr       (addr),
    .cmd_vld    (cmd_vld),
    .cmd_op     (cmd_op),
    .cmd_data   (cmd_data),
    .do_o       (do_o),
    .do_oe      (do_oe),
    .waiting    (waiting),
    .rd_active  (rd_active),
    .stat_shown (stat_shown)
  );

  tw_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYC(BUSY_CYC)) u_store (
    .clk      (clk),
    .rst      (rst),
    .cmd_vld  (cmd_vld),
    .cmd_op   (cmd_op),
    .addr     (addr),
    .cmd_data (cmd_data),
    .rd_data  (rd_data),
    .prog_go  (prog_go),
    .busy     (busy),
    .wen      (wen)
  );
endmodule

// File: rtl/tw_serial_front_chk.sv
module tw_serial_front_chk (
  input logic clk,
  input logic rst,
  input logic cs_s,
  input logic sk_rise,
  input logic di_s,
  input logic do_o,
  input logic do_oe,
  input logic waiting,
  input logic rd_active,
  input logic stat_shown,
  input logic busy,
  input logic wen
);
  AST_STANDBY_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (!cs_s && !$past(cs_s)) |-> !do_oe); // R4

  AST_IDLE_PULSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (waiting && cs_s && sk_rise && !di_s) |=> waiting); // R2

  AST_READ_LEAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_active) |-> !do_o); // R6

  AST_LOCKED_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wen)); // R9

  AST_STATUS_BUSY_LOW: assert property (@(posedge clk) disable iff (rst)
    (stat_shown && busy) |-> (do_oe && !do_o)); // R10

  AST_BUSY_NO_FRAME: assert property (@(posedge clk) disable iff (rst)
    (stat_shown && busy && cs_s && sk_rise) |=> waiting); // R11
endmodule

bind tw_serial_front tw_serial_front_chk u_chk (.*);

// File: tb/tw_serial_front_bench.sv
`timescale 1ns/1ps
module tw_serial_front_bench;
  localparam int BUSY = 48;

  logic clk = 1'b0, rst = 1'b1, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o, do_oe;
  int   n_chk = 0, n_bad = 0;
  bit   glitch = 1'b0;
  logic [15:0] rv;

  always #5 clk = ~clk;

  tw_serial_front #(.ADDR_W(6), .DATA_W(16), .CS_GAP(6), .BUSY_CYC(BUSY)) u_tw_serial_front (
    .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di), .do_o(do_o), .do_oe(do_oe)
  );

  // {kind(0 write,1 erase), addr, write data, expected read}
  localparam logic [39:0] VEC [8] = '{
    {2'd0, 6'd3,  16'hA5C3, 16'hA5C3},
    {2'd0, 6'd0,  16'h0001, 16'h0001},
    {2'd0, 6'd63, 16'h8000, 16'h8000},
    {2'd0, 6'd21, 16'hFFFF, 16'hFFFF},
    {2'd0, 6'd3,  16'h1234, 16'h1234},
    {2'd1, 6'd0,  16'h0000, 16'hFFFF},
    {2'd0, 6'd42, 16'h0000, 16'h0000},
    {2'd1, 6'd63, 16'h0000, 16'hFFFF}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    @(negedge clk); di = b;
    repeat (3) @(negedge clk);
    sk = 1'b1;
    repeat (2) @(negedge clk);
    if (glitch) di = ~b;
    repeat (2) @(negedge clk);
    sk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) pulse(v[i]);
  endtask

  task automatic cs_up();
    @(negedge clk); cs = 1'b1; repeat (4) @(negedge clk);
  endtask

  task automatic cs_down();
    @(negedge clk); cs = 1'b0; di = 1'b0; repeat (16) @(negedge clk);
  endtask

  task automatic prog(input logic [1:0] code, input logic [5:0] a, input logic [15:0] d, input bit hasd);
    cs_up(); pulse(1'b1); send({14'd0, code}, 2); send({10'd0, a}, 6);
    if (hasd) send(d, 16);
    cs_down(); repeat (BUSY + 20) @(negedge clk);
  endtask

  // code 10 and address, after the framing bit; R6 dummy and release checks
  task automatic rd_tail(input logic [5:0] a, output logic [15:0] v);
    send(16'h0002, 2); send({10'd0, a}, 6);
    chk("R6 lead zero", {14'd0, do_oe, do_o}, 16'h0002);
    for (int i = 15; i >= 0; i--) begin pulse(1'b0); v[i] = do_o; end
    pulse(1'b0);
    chk("R6 release", {15'd0, do_oe}, 16'h0000);
  endtask

  task automatic rd(input logic [5:0] a, input int ndum, output logic [15:0] v);
    cs_up(); repeat (ndum) pulse(1'b0); pulse(1'b1); rd_tail(a, v); cs_down();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 oe after reset", {15'd0, do_oe}, 16'h0000);
    rd(6'd5, 0, rv); chk("R12 word cleared", rv, 16'h0000);

    // locked: write must be ignored, no status shown
    prog(2'b01, 6'd5, 16'hBEEF, 1);
    cs_up(); repeat (3) @(negedge clk);
    chk("R9 no status when locked", {15'd0, do_oe}, 16'h0000);
    cs_down();
    rd(6'd5, 0, rv); chk("R9 locked write ignored", rv, 16'h0000);

    prog(2'b00, 6'b110000, 16'h0, 0); // unlock, R3
    for (int k = 0; k < 8; k++) begin
      if (VEC[k][39:38] == 2'd0) prog(2'b01, VEC[k][37:32], VEC[k][31:16], 1);
      else                       prog(2'b11, VEC[k][37:32], 16'h0, 0);
      rd(VEC[k][37:32], 0, rv);
      chk(VEC[k][39:38] == 2'd0 ? "R3 R7 write readback" : "R8 erase readback", rv, VEC[k][15:0]);
    end

    // R13 R2: 7 idle pulses then a 9-clock read header fills a 16-clock frame
    rd(6'd3, 7, rv); chk("R13 R2 padded read", rv, 16'h1234);

    // R1: DI flips while SK high; only the rising-edge value counts
    glitch = 1'b1; rd(6'd21, 0, rv); glitch = 1'b0;
    chk("R1 sampled at rising edge", rv, 16'hFFFF);

    // R4: SK/DI activity while deselected
    repeat (5) pulse(1'b1);
    chk("R4 standby oe", {15'd0, do_oe}, 16'h0000);
    cs_up(); repeat (3) @(negedge clk);
    chk("R4 no frame from standby", {15'd0, do_oe}, 16'h0000);
    cs_down();
    rd(6'd3, 0, rv); chk("R4 standby no effect", rv, 16'h1234);

    // R7: truncated write discarded
    cs_up(); pulse(1'b1); send(16'h0001, 2); send(16'h0003, 6); send(16'h00AA, 8);
    cs_down(); repeat (BUSY + 20) @(negedge clk);
    rd(6'd3, 0, rv); chk("R7 truncated write", rv, 16'h1234);

    // R5: too-short deselect rejects the next selection
    cs_up(); @(negedge clk); cs = 1'b0; repeat (3) @(negedge clk); cs = 1'b1;
    repeat (4) @(negedge clk);
    pulse(1'b1); send(16'h0002, 2); send(16'h0003, 6);
    chk("R5 short gap rejected", {15'd0, do_oe}, 16'h0000);
    pulse(1'b0);
    chk("R5 short gap stays quiet", {15'd0, do_oe}, 16'h0000);
    cs_down();
    rd(6'd3, 0, rv); chk("R5 normal after gap", rv, 16'h1234);

    // R10 R11: status period, DI low then DI high as framing bit
    cs_up(); pulse(1'b1); send(16'h0001, 2); send(16'd10, 6); send(16'h5A5A, 16);
    @(negedge clk); cs = 1'b0; repeat (10) @(negedge clk); cs = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 busy shown low", {14'd0, do_oe, do_o}, 16'h0002);
    repeat (BUSY + 10) @(negedge clk);
    chk("R10 ready shown high", {14'd0, do_oe, do_o}, 16'h0003);
    repeat (3) pulse(1'b0);
    chk("R11 DI low keeps status", {14'd0, do_oe, do_o}, 16'h0003);
    pulse(1'b1);
    chk("R11 status cleared by framing bit", {15'd0, do_oe}, 16'h0000);
    rd_tail(6'd10, rv); chk("R11 read after status start", rv, 16'h5A5A);
    cs_down();

    // R11: DI high while busy is ignored
    cs_up(); pulse(1'b1); send(16'h0001, 2); send(16'd11, 6); send(16'h0F0F, 16);
    @(negedge clk); cs = 1'b0; repeat (10) @(negedge clk); cs = 1'b1;
    repeat (4) @(negedge clk);
    pulse(1'b1);
    chk("R11 busy ignores DI high", {14'd0, do_oe, do_o}, 16'h0002);
    repeat (BUSY + 10) @(negedge clk);
    pulse(1'b1);
    rd_tail(6'd11, rv); chk("R11 read after busy", rv, 16'h0F0F);
    cs_down();

    // R8 fill and erase all, R9 lock
    prog(2'b00, 6'b010000, 16'hC33C, 1);
    rd(6'd0, 0, rv);  chk("R8 write-all low word", rv, 16'hC33C);
    rd(6'd63, 0, rv); chk("R8 write-all high word", rv, 16'hC33C);
    prog(2'b00, 6'b100000, 16'h0, 0);
    rd(6'd17, 0, rv); chk("R8 erase-all", rv, 16'hFFFF);
    prog(2'b00, 6'b000000, 16'h0, 0);
    prog(2'b01, 6'd17, 16'h0000, 1);
    rd(6'd17, 0, rv); chk("R9 lock blocks write", rv, 16'hFFFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule